// File: doc/BRIEF.md
# NAND Vendor Parameter Command Sequencer

This block carries out two fixed vendor parameter procedures on a raw NAND byte interface. It turns each step into an abstract cycle request: command, address, data-out, reset, or page read. A downstream NAND engine consumes these requests through a valid/ready handshake and handles electrical timing and ready/busy polling.

The first procedure selects a read-retry mode. The sequencer enters parameter mode, then writes each internal retry register in a fixed order. The value for each register comes from an external per-mode table. Finally the sequencer commits the new settings.

The second procedure extracts the retry-parameter OTP page. It runs the following phases in order:
- It resets the device, arms a private register, and issues a three-command OTP-entry chain.
- It reads the OTP page and forwards each byte on an output stream.
- It restores normal mode with a second reset, a register clear, a commit, and a zero-length dummy read.

If any accepted request comes back with a failure, the procedure ends at once with an error.

The FSM has four states:
- **IDLE**: waiting. `start` takes the operation, mode and layout and moves to **ISSUE** at step 0.
- **ISSUE**: presents the current step's request. The next state depends on how the request is accepted:
  - A failed acceptance goes to **DONE** with an error (abort).
  - An accepted read of non-zero length goes to **RDATA**.
  - An accepted last step goes to **DONE**.
  - Any other accepted step advances the step index and stays in **ISSUE**.
- **RDATA**: counts incoming page bytes. After the final byte it goes to **DONE** if this was the last step, or back to **ISSUE** at the next step otherwise.
- **DONE**: pulses `done` for one clock and returns to **IDLE**.

Top module: `nand_vparam_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `req_valid` and `otp_valid` are all low.
- R2: With `op_sel`=0 (retry select), the first request is command 0x36, the last is command 0x16, and between them come NREGS pairs of one address request followed by one data-out request. Total requests: 2*NREGS+2. `req_kind` codes: 0 command, 1 address, 2 data-out, 3 reset, 4 page read.
- R3: The address requests of a retry select carry the register offsets 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF, in that order.
- R4: The data-out request for register i is presented while `tbl_addr` = mode*NREGS+i, and it carries `tbl_data`.
- R5: With `op_sel`=1 (OTP extract), the first nine requests are: reset; command 0x36; address 0x38; data-out 0x52; command 0x16; commands 0x17, 0x04, 0x19; page read.
- R6: The OTP page read uses page 0x21F with length 784 when `layout_sel`=0, and page 0x200 with length 528 when `layout_sel`=1. Exactly that many `din` bytes are forwarded in order on `otp_valid`/`otp_byte`, each one cycle after it is accepted.
- R7: After the OTP read, the remaining six requests are: reset; command 0x36; address 0x38; data-out 0x00; command 0x16; page read of page 0 with length 0. The zero-length read accepts no data bytes.
- R8: While `req_valid` is high and `req_ready` is low, the request stays valid and its contents do not change.
- R9: If a request is accepted with `req_err` high, no further request is issued, and the next cycle shows `done` and `err` together.
- R10: A `start` while `busy` is high is ignored: the running operation continues unchanged and no extra operation follows.
- R11: `busy` is high from the cycle after `start` until `done`. `done` is high for exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, taken when idle |
| op_sel | input | 1 | 0 retry select, 1 OTP extract |
| layout_sel | input | 1 | OTP layout: 0 large page, 1 small page |
| mode_idx | input | MODE_W | Retry mode index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end pulse |
| err | output | 1 | High with `done` when aborted |
| tbl_addr | output | TBL_AW | Per-mode value table address |
| tbl_data | input | 8 | Table value at `tbl_addr` |
| req_valid | output | 1 | Cycle request valid |
| req_ready | input | 1 | Request accepted |
| req_err | input | 1 | Accepted request failed |
| req_kind | output | 3 | Request kind code |
| req_byte | output | 8 | Command, address or data byte |
| req_page | output | PAGE_W | Page for a read request |
| req_len | output | LEN_W | Byte count for a read request |
| din_valid | input | 1 | Page byte valid |
| din_byte | input | 8 | Page byte |
| otp_valid | output | 1 | Forwarded OTP byte valid |
| otp_byte | output | 8 | Forwarded OTP byte |

## Verification
The following properties are checked by assertions on every cycle:
- the one-cycle `done` pulse;
- stability of a request held back by `req_ready`;
- the error-to-done timing;
- that a busy `start` leaves the latched operation alone;
- that the OTP stream never fires outside an extract;
- that the byte count stays below the read length.

Only the bench scenarios can show that the order and contents of the request sequences are correct:
- every retry mode is swept;
- both OTP layouts are run, with and without handshake stalls;
- an abort is injected at every step of both procedures.

// File: rtl/nvp_pkg.sv
package nvp_pkg;

    typedef enum logic [2:0] {
        K_CMD   = 3'd0,
        K_ADDR  = 3'd1,
        K_DOUT  = 3'd2,
        K_RESET = 3'd3,
        K_READ  = 3'd4
    } nvp_kind_e;

    typedef struct packed {
        nvp_kind_e  kind;
        logic [7:0] val;
        logic       use_tbl;
        logic       rd_main;
        logic       last;
    } nvp_step_t;

    localparam logic [7:0] C_ENTER  = 8'h36;
    localparam logic [7:0] C_COMMIT = 8'h16;
    localparam logic [7:0] C_OTP_A  = 8'h17;
    localparam logic [7:0] C_OTP_B  = 8'h04;
    localparam logic [7:0] C_OTP_C  = 8'h19;
    localparam logic [7:0] OTP_REG  = 8'h38;
    localparam logic [7:0] OTP_ON   = 8'h52;
    localparam logic [7:0] OTP_OFF  = 8'h00;
    localparam int         OTP_STEPS = 15;

    function automatic logic [7:0] rr_offset(input logic [2:0] i);
        case (i)
            3'd0:    return 8'hCC;
            3'd1:    return 8'hBF;
            3'd2:    return 8'hAA;
            3'd3:    return 8'hAB;
            3'd4:    return 8'hCD;
            3'd5:    return 8'hAD;
            3'd6:    return 8'hAE;
            default: return 8'hAF;
        endcase
    endfunction

    function automatic nvp_step_t mk_step(input nvp_kind_e k, input logic [7:0] v,
                                          input logic tbl, input logic rdm,
                                          input logic lst);
        nvp_step_t s;
        s.kind = k;
        s.val = v;
        s.use_tbl = tbl;
        s.rd_main = rdm;
        s.last = lst;
        return s;
    endfunction

endpackage

// File: rtl/nvp_step_rom.sv
module nvp_step_rom
    import nvp_pkg::*;
#(
    parameter int NREGS  = 8,
    parameter int STEP_W = 5,
    parameter int IDX_W  = 3
) (
    input  logic              op_otp,
    input  logic [STEP_W-1:0] step,
    output nvp_step_t         st,
    output logic [IDX_W-1:0]  reg_idx
);
    localparam int RR_LAST = 2 * NREGS + 1;

    int j;

    always_comb begin
        st = mk_step(K_CMD, 8'h00, 1'b0, 1'b0, 1'b1);
        reg_idx = '0;
        j = int'(step) - 1;
        if (!op_otp) begin
            if (step == '0) begin
                st = mk_step(K_CMD, C_ENTER, 1'b0, 1'b0, 1'b0);
            end else if (int'(step) < RR_LAST) begin
                reg_idx = IDX_W'(j / 2);
                if (j % 2 == 0) begin
                    st = mk_step(K_ADDR, rr_offset(3'(j / 2)), 1'b0, 1'b0, 1'b0);
                end else begin
                    st = mk_step(K_DOUT, 8'h00, 1'b1, 1'b0, 1'b0);
                end
            end else if (int'(step) == RR_LAST) begin
                st = mk_step(K_CMD, C_COMMIT, 1'b0, 1'b0, 1'b1);
            end
        end else begin
            case (int'(step))
                0:  st = mk_step(K_RESET, 8'h00,    1'b0, 1'b0, 1'b0);
                1:  st = mk_step(K_CMD,   C_ENTER,  1'b0, 1'b0, 1'b0);
                2:  st = mk_step(K_ADDR,  OTP_REG,  1'b0, 1'b0, 1'b0);
                3:  st = mk_step(K_DOUT,  OTP_ON,   1'b0, 1'b0, 1'b0);
                4:  st = mk_step(K_CMD,   C_COMMIT, 1'b0, 1'b0, 1'b0);
                5:  st = mk_step(K_CMD,   C_OTP_A,  1'b0, 1'b0, 1'b0);
                6:  st = mk_step(K_CMD,   C_OTP_B,  1'b0, 1'b0, 1'b0);
                7:  st = mk_step(K_CMD,   C_OTP_C,  1'b0, 1'b0, 1'b0);
                8:  st = mk_step(K_READ,  8'h00,    1'b0, 1'b1, 1'b0);
                9:  st = mk_step(K_RESET, 8'h00,    1'b0, 1'b0, 1'b0);
                10: st = mk_step(K_CMD,   C_ENTER,  1'b0, 1'b0, 1'b0);
                11: st = mk_step(K_ADDR,  OTP_REG,  1'b0, 1'b0, 1'b0);
                12: st = mk_step(K_DOUT,  OTP_OFF,  1'b0, 1'b0, 1'b0);
                13: st = mk_step(K_CMD,   C_COMMIT, 1'b0, 1'b0, 1'b0);
                14: st = mk_step(K_READ,  8'h00,    1'b0, 1'b0, 1'b1);
                default: st = mk_step(K_CMD, 8'h00, 1'b0, 1'b0, 1'b1);
            endcase
        end
    end

endmodule

// File: rtl/nvp_beat_cnt.sv
module nvp_beat_cnt #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [LEN_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/nand_vparam_seq.sv
module nand_vparam_seq
    import nvp_pkg::*;
#(
    parameter int NREGS      = 8,
    parameter int NMODES     = 8,
    parameter int PAGE_W     = 24,
    parameter int LEN_W      = 16,
    parameter int OTP_PAGE_A = 'h21F,
    parameter int OTP_LEN_A  = 784,
    parameter int OTP_PAGE_B = 'h200,
    parameter int OTP_LEN_B  = 528,
    localparam int MODE_W    = $clog2(NMODES),
    localparam int IDX_W     = $clog2(NREGS),
    localparam int TBL_AW    = $clog2(NREGS * NMODES),
    localparam int RR_STEPS  = 2 * NREGS + 2,
    localparam int MAX_STEPS = (RR_STEPS > OTP_STEPS) ? RR_STEPS : OTP_STEPS,
    localparam int STEP_W    = $clog2(MAX_STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_sel,
    input  logic              layout_sel,
    input  logic [MODE_W-1:0] mode_idx,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [TBL_AW-1:0] tbl_addr,
    input  logic [7:0]        tbl_data,
    output logic              req_valid,
    input  logic              req_ready,
    input  logic              req_err,
    output logic [2:0]        req_kind,
    output logic [7:0]        req_byte,
    output logic [PAGE_W-1:0] req_page,
    output logic [LEN_W-1:0]  req_len,
    input  logic              din_valid,
    input  logic [7:0]        din_byte,
    output logic              otp_valid,
    output logic [7:0]        otp_byte
);
    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_RDATA, S_DONE} state_e;

    state_e             state_q, state_d;
    logic [STEP_W-1:0]  step_q, step_d;
    logic               op_q, lay_q, err_q, err_d;
    logic [MODE_W-1:0]  mode_q;
    nvp_step_t          st;
    logic [IDX_W-1:0]   reg_idx;
    logic [LEN_W-1:0]   beat_cnt, cur_len;
    logic [PAGE_W-1:0]  cur_page;
    logic               accept, last_beat;

    nvp_step_rom #(.NREGS(NREGS), .STEP_W(STEP_W), .IDX_W(IDX_W)) u_rom (
        .op_otp (op_q),
        .step   (step_q),
        .st     (st),
        .reg_idx(reg_idx)
    );

    nvp_beat_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q == S_ISSUE),
        .inc  (state_q == S_RDATA && din_valid),
        .cnt  (beat_cnt)
    );

    always_comb begin
        cur_page = '0;
        cur_len  = '0;
        if (st.kind == K_READ && st.rd_main) begin
            cur_page = lay_q ? PAGE_W'(OTP_PAGE_B) : PAGE_W'(OTP_PAGE_A);
            cur_len  = lay_q ? LEN_W'(OTP_LEN_B) : LEN_W'(OTP_LEN_A);
        end
    end

    assign accept    = (state_q == S_ISSUE) && req_ready;
    assign last_beat = din_valid && (beat_cnt == cur_len - LEN_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        err_d   = err_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = S_ISSUE;
                    step_d  = '0;
                    err_d   = 1'b0;
                end
            end
            S_ISSUE: begin
                if (accept) begin
                    if (req_err) begin
                        state_d = S_DONE;
                        err_d   = 1'b1;
                    end else if (st.kind == K_READ && cur_len != '0) begin
                        state_d = S_RDATA;
                    end else if (st.last) begin
                        state_d = S_DONE;
                    end else begin
                        step_d = step_q + 1'b1;
                    end
                end
            end
            S_RDATA: begin
                if (last_beat) begin
                    if (st.last) begin
                        state_d = S_DONE;
                    end else begin
                        state_d = S_ISSUE;
                        step_d  = step_q + 1'b1;
                    end
                end
            end
            S_DONE: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= '0;
            err_q   <= 1'b0;
            op_q    <= 1'b0;
            lay_q   <= 1'b0;
            mode_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            err_q   <= err_d;
            if (state_q == S_IDLE && start) begin
                op_q   <= op_sel;
                lay_q  <= layout_sel;
                mode_q <= mode_idx;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_DONE);
        err       = (state_q == S_DONE) && err_q;
        req_valid = (state_q == S_ISSUE);
        req_kind  = st.kind;
        req_byte  = st.use_tbl ? tbl_data : st.val;
        req_page  = cur_page;
        req_len   = cur_len;
        tbl_addr  = TBL_AW'(int'(mode_q) * NREGS + int'(reg_idx));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            otp_valid <= 1'b0;
            otp_byte  <= '0;
        end else begin
            otp_valid <= (state_q == S_RDATA) && din_valid;
            otp_byte  <= din_byte;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!req_valid && !done && !err));
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_kind) && $stable(req_byte)
                                       && $stable(req_page) && $stable(req_len)));
    assert_abort_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_err) |=> (done && err));
    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(op_q) && $stable(mode_q) && $stable(lay_q)));
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_otp_only_extract_R6: assert property (@(posedge clk) disable iff (!rst_n)
        otp_valid |-> op_q);
    assert_beats_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RDATA) |-> (beat_cnt < cur_len));

endmodule

// File: tb/tb_nand_vparam_seq.sv
module tb_nand_vparam_seq;
    localparam int NREGS = 8;
    localparam int NMODES = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, op_sel = 1'b0, layout_sel = 1'b0;
    logic [2:0] mode_idx = '0;
    logic busy, done, err, req_valid, otp_valid;
    logic [5:0] tbl_addr;
    logic [7:0] tbl_data, req_byte, otp_byte;
    logic req_ready = 1'b0, req_err = 1'b0, din_valid = 1'b0;
    logic [7:0] din_byte = '0;
    logic [2:0] req_kind;
    logic [23:0] req_page;
    logic [15:0] req_len;

    always #2 clk = ~clk;

    assign tbl_data = 8'((int'(tbl_addr) * 37) + 11);

    nand_vparam_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .layout_sel(layout_sel), .mode_idx(mode_idx), .busy(busy), .done(done),
        .err(err), .tbl_addr(tbl_addr), .tbl_data(tbl_data), .req_valid(req_valid),
        .req_ready(req_ready), .req_err(req_err), .req_kind(req_kind),
        .req_byte(req_byte), .req_page(req_page), .req_len(req_len),
        .din_valid(din_valid), .din_byte(din_byte), .otp_valid(otp_valid),
        .otp_byte(otp_byte)
    );

    int total = 0, bad = 0, cyc = 0;
    int nacc, pend, didx, ocnt, ndone, last_err, hold_bad, err_at, cur_lay;
    bit stall, holding;
    int rk[0:31], rb[0:31], rp[0:31], rl[0:31], ta[0:31];
    int obuf[0:1023];
    int ek[0:31], eb[0:31], ep[0:31], el[0:31];
    int hk, hb, hp, hl;
    int offs[0:7] = '{'hCC, 'hBF, 'hAA, 'hAB, 'hCD, 'hAD, 'hAE, 'hAF};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int din_val(input int k, input int lay);
        return (k * 13 + lay * 5 + 1) & 255;
    endfunction

    // NAND-side model, all driving and sampling at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (pend > 0 && (!stall || cyc % 2 == 0)) begin
                din_valid = 1'b1;
                din_byte = 8'(din_val(didx, cur_lay));
                didx++;
                pend--;
            end else begin
                din_valid = 1'b0;
            end
            if (holding) begin
                if (!req_valid || int'(req_kind) != hk || int'(req_byte) != hb ||
                    int'(req_page) != hp || int'(req_len) != hl) hold_bad++;
            end
            req_ready = !stall || (cyc % 3 != 0);
            req_err = req_ready && req_valid && (nacc == err_at);
            holding = req_valid && !req_ready;
            hk = int'(req_kind); hb = int'(req_byte); hp = int'(req_page); hl = int'(req_len);
            if (req_valid && req_ready && nacc < 32) begin
                rk[nacc] = int'(req_kind); rb[nacc] = int'(req_byte);
                rp[nacc] = int'(req_page); rl[nacc] = int'(req_len);
                ta[nacc] = int'(tbl_addr);
                if (req_kind == 3'd4 && !req_err) begin
                    pend = int'(req_len);
                    didx = 0;
                end
                nacc++;
            end
            if (otp_valid && ocnt < 1024) begin
                obuf[ocnt] = int'(otp_byte);
                ocnt++;
            end
            if (done) begin
                ndone++;
                last_err = int'(err);
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (cyc > 150000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic build_exp(input bit op, input int mode, input int lay, output int n);
        if (!op) begin
            ek[0] = 0; eb[0] = 'h36; ep[0] = 0; el[0] = 0;
            for (int i = 0; i < NREGS; i++) begin
                ek[1 + 2 * i] = 1; eb[1 + 2 * i] = offs[i];
                ep[1 + 2 * i] = 0; el[1 + 2 * i] = 0;
                ek[2 + 2 * i] = 2; eb[2 + 2 * i] = ((mode * NREGS + i) * 37 + 11) & 255;
                ep[2 + 2 * i] = 0; el[2 + 2 * i] = 0;
            end
            ek[2 * NREGS + 1] = 0; eb[2 * NREGS + 1] = 'h16;
            ep[2 * NREGS + 1] = 0; el[2 * NREGS + 1] = 0;
            n = 2 * NREGS + 2;
        end else begin
            ek = '{default: 0}; eb = '{default: 0}; ep = '{default: 0}; el = '{default: 0};
            ek[0] = 3; eb[1] = 'h36; ek[2] = 1; eb[2] = 'h38; ek[3] = 2; eb[3] = 'h52;
            eb[4] = 'h16; eb[5] = 'h17; eb[6] = 'h04; eb[7] = 'h19;
            ek[8] = 4; ep[8] = lay ? 'h200 : 'h21F; el[8] = lay ? 528 : 784;
            ek[9] = 3; eb[10] = 'h36; ek[11] = 1; eb[11] = 'h38; ek[12] = 2; eb[12] = 'h00;
            eb[13] = 'h16; ek[14] = 4;
            n = 15;
        end
    endtask

    function automatic string tag_of(input bit op, input int k, input int n);
        if (!op) return (k == 0 || k == n - 1) ? "R2" : ((k % 2 == 1) ? "R3" : "R4");
        if (k == 8) return "R6";
        return (k < 8) ? "R5" : "R7";
    endfunction

    // run one operation; eat = step index to fail (-1 none); busy_kick pulses start mid-run
    task automatic run_op(input bit op, input int mode, input int lay, input bit stl,
                          input int eat, input bit busy_kick);
        int n, wait_c, exp_n;
        @(negedge clk); #1;
        nacc = 0; ocnt = 0; ndone = 0; last_err = 0; pend = 0; didx = 0;
        hold_bad = 0; holding = 0; stall = stl; err_at = eat; cur_lay = lay;
        op_sel = op; mode_idx = 3'(mode); layout_sel = lay[0];
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        check(busy === 1'b1, "R11 busy after start", int'(busy), 1);
        if (busy_kick) begin
            repeat (3) @(negedge clk);
            #1;
            op_sel = ~op; mode_idx = 3'(mode + 1); start = 1'b1;
            @(negedge clk); #1;
            start = 1'b0;
        end
        wait_c = 0;
        while (ndone == 0 && wait_c < 20000) begin
            @(negedge clk); #1;
            wait_c++;
        end
        repeat (6) @(negedge clk);
        #1;
        build_exp(op, mode, lay, n);
        exp_n = (eat >= 0) ? eat + 1 : n;
        check(nacc == exp_n, (eat >= 0) ? "R9 request count" : "R2/R5 request count", nacc, exp_n);
        for (int k = 0; k < nacc && k < n; k++) begin
            check(rk[k] == ek[k] && rb[k] == eb[k] && rp[k] == ep[k] && rl[k] == el[k],
                  tag_of(op, k, n), rk[k] * 256 + rb[k], ek[k] * 256 + eb[k]);
            if (rk[k] == 4) check(rp[k] == ep[k] && rl[k] == el[k],
                                  (k == 8) ? "R6 page/len" : "R7 dummy len", rl[k], el[k]);
            if (!op && k % 2 == 0 && k > 0 && k < n - 1)
                check(ta[k] == mode * NREGS + (k - 2) / 2, "R4 tbl_addr", ta[k], mode * NREGS + (k - 2) / 2);
        end
        check(ndone == 1, "R11 done pulse count", ndone, 1);
        check(last_err == (eat >= 0 ? 1 : 0), "R9 err with done", last_err, eat >= 0 ? 1 : 0);
        check(busy == 1'b0 && req_valid == 1'b0, "R10 idle after single op", int'(busy), 0);
        if (stl) check(hold_bad == 0, "R8 request hold", hold_bad, 0);
        if (op && eat < 0) begin
            int explen = lay ? 528 : 784;
            int mism = 0;
            check(ocnt == explen, "R6 otp byte count", ocnt, explen);
            for (int k = 0; k < ocnt && k < explen; k++)
                if (obuf[k] != din_val(k, lay)) mism++;
            check(mism == 0, "R6 otp byte values", mism, 0);
        end else if (op && eat >= 0 && eat < 8) begin
            check(ocnt == 0, "R9 no data after abort", ocnt, 0);
        end
    endtask

    initial begin
        nacc = 0; pend = 0; didx = 0; ocnt = 0; ndone = 0; last_err = 0;
        hold_bad = 0; err_at = -1; cur_lay = 0; stall = 0; holding = 0;
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && err == 0 && req_valid == 0 && otp_valid == 0,
              "R1 reset outputs", int'({busy, done, err, req_valid, otp_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && req_valid == 0, "R1 idle after reset", int'({busy, req_valid}), 0);
        for (int m = 0; m < NMODES; m++) run_op(1'b0, m, 0, m[0], -1, 1'b0);
        run_op(1'b1, 0, 0, 1'b0, -1, 1'b0);
        run_op(1'b1, 0, 1, 1'b0, -1, 1'b0);
        run_op(1'b1, 0, 0, 1'b1, -1, 1'b0);
        run_op(1'b1, 0, 1, 1'b1, -1, 1'b0);
        run_op(1'b0, 5, 0, 1'b0, -1, 1'b1);
        run_op(1'b1, 0, 1, 1'b0, -1, 1'b1);
        for (int e = 0; e < 2 * NREGS + 2; e++) run_op(1'b0, 3, 0, 1'b0, e, 1'b0);
        for (int e = 0; e < 15; e++) run_op(1'b1, 0, 1, 1'b0, e, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule